// File: doc/BRIEF.md
# Stride-Detecting Prefetch Engine

This block sits next to a cache and watches the demand access stream one access at a time. Each access carries an address and a read/write flag. Reads and writes are followed separately. For each type the block takes the distance between the current address and the previous address of that type, and it learns a stride when the same distance keeps coming back. Once a stride has been confirmed, the block asks for the line the stream should touch next. It does this on a single request port with a valid/ready handshake.

Hysteresis guards both directions. Prefetching for a type starts only after the same stride has been seen more than three times in a row. It stops only after more than three consecutive strides that differ from the learned one. Every prefetch address is rounded down to a cache-line boundary. A request for the same line as the last issued prefetch is not repeated. The output holds only one request. If a new request is made while an older one has not yet been taken, the older one is dropped.

Top module: `stride_prefetch`

## Requirements
- R1: After reset, `pf_valid` is 0 and `pf_addr` is 0, every stored stride is 0 and prefetching is inactive for both types.
- R2: The first access of each type after reset only records its address. It yields no stride, touches no counter and produces no prefetch.
- R3: The stride is the current address minus the previous address of the same type, in wrap-around arithmetic. Reads (`acc_write`=0) and writes (`acc_write`=1) each keep their own previous address, stride, counters and active flag, so interleaving the two types does not disturb either one.
- R4: While inactive, an access whose stride equals the stored stride raises the same-stride count. When that count exceeds ON_THRESH (default 3), the type becomes active and a prefetch to the current address plus the stride is made. The request appears on `pf_valid`/`pf_addr` in the cycle after the access.
- R5: While active, every access whose stride equals the learned stride makes a prefetch to its address plus the stride. Such an access also clears the differing-stride count.
- R6: While active, a stride that differs from the learned one raises the differing-stride count. When that count exceeds OFF_THRESH (default 3), the type becomes inactive, the differing stride becomes the stored stride, and the same-stride count becomes 1.
- R7: While inactive, a stride that differs from the stored one replaces it and sets the same-stride count to 1. From then on, three further equal strides are needed to activate.
- R8: `pf_addr` is always aligned to LINE_BYTES (default 64, so bits [5:0] are 0). A request whose line equals the line of the last issued prefetch is suppressed and leaves the output as it was.
- R9: While `pf_valid` is 1 and `pf_ready` is 0, the request is held with a stable address. A new request made in that state replaces it, and the older one is lost.
- R10: A request is taken when `pf_valid` and `pf_ready` are both 1 at a clock edge. If no new request is made in that cycle, `pf_valid` is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A demand access is present this cycle |
| acc_addr | input | AW | Byte address of the demand access |
| acc_write | input | 1 | 1 for a write access, 0 for a read access |
| pf_valid | output | 1 | Prefetch request pending |
| pf_addr | output | AW | Line-aligned prefetch address |
| pf_ready | input | 1 | Consumer takes the pending request |

## Verification
Two things can happen in the same cycle. A pending request can be taken by the consumer, and a fresh request can be generated by a matching access. In that cycle the output must show the fresh address and stay valid, not go low. The bench provokes this by running an active stride stream with `pf_ready` held high. It also mixes random `pf_ready` patterns with random strided and noisy traffic, so the cases of accept with no new request, new request with no accept, and replacement while stalled all occur next to one another. Each cycle's `pf_valid` and `pf_addr` are judged against a bench model built from the requirements.

// File: rtl/pf_pkg.sv
package pf_pkg;
  // access type selects which stride tracker is updated
  typedef enum logic [0:0] {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;

  localparam int NUM_OPS = 2;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pf_stride_track.sv
module pf_stride_track #(
  parameter int AW      = 32,
  parameter int CNT_W   = 3,
  parameter int ON_TH   = 3,
  parameter int OFF_TH  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          issue,
  output logic [AW-1:0] target
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic          seen_q;
  logic          active_q;
  logic [AW-1:0] prev_q;
  logic [AW-1:0] stride_q;
  logic [CNT_W-1:0] same_q;
  logic [CNT_W-1:0] diff_q;

  logic [AW-1:0] delta;
  logic          match;
  logic [CNT_W-1:0] same_inc;
  logic [CNT_W-1:0] diff_inc;
  logic          turn_on;
  logic          turn_off;

  always_comb begin
    delta    = addr - prev_q;
    match    = (delta == stride_q);
    same_inc = (same_q == CNT_MAX) ? same_q : same_q + 1'b1;
    diff_inc = (diff_q == CNT_MAX) ? diff_q : diff_q + 1'b1;
    turn_on  = !active_q && match && (same_inc > CNT_W'(ON_TH));
    turn_off = active_q && !match && (diff_inc > CNT_W'(OFF_TH));
    issue    = en && seen_q && match && (active_q || turn_on);
    target   = addr + stride_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      active_q <= 1'b0;
      prev_q   <= '0;
      stride_q <= '0;
      same_q   <= '0;
      diff_q   <= '0;
    end else if (en) begin
      prev_q <= addr;
      if (!seen_q) begin
        seen_q <= 1'b1;
      end else if (active_q) begin
        if (match) begin
          diff_q <= '0;
        end else if (turn_off) begin
          active_q <= 1'b0;
          stride_q <= delta;
          same_q   <= CNT_W'(1);
          diff_q   <= '0;
        end else begin
          diff_q <= diff_inc;
        end
      end else begin
        if (match) begin
          same_q <= same_inc;
          if (turn_on) begin
            active_q <= 1'b1;
            diff_q   <= '0;
          end
        end else begin
          stride_q <= delta;
          same_q   <= CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pf_issue.sv
module pf_issue #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] target,
  output logic          pf_valid,
  output logic [AW-1:0] pf_addr,
  input  logic          pf_ready
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam logic [AW-1:0] LINE_MASK = ~AW'(LINE_BYTES - 1);

  logic [AW-1:0] line;
  logic [AW-1:0] last_line_q;
  logic          last_vld_q;
  logic          fresh;

  always_comb begin
    line  = target & LINE_MASK;
    fresh = req && !(last_vld_q && (line[AW-1:OFF_W] == last_line_q[AW-1:OFF_W]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid    <= 1'b0;
      pf_addr     <= '0;
      last_line_q <= '0;
      last_vld_q  <= 1'b0;
    end else if (fresh) begin
      pf_valid    <= 1'b1;
      pf_addr     <= line;
      last_line_q <= line;
      last_vld_q  <= 1'b1;
    end else if (pf_ready) begin
      pf_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stride_prefetch.sv
module stride_prefetch #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int ON_THRESH  = 3,
  parameter int OFF_THRESH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_write,
  output logic          pf_valid,
  output logic [AW-1:0] pf_addr,
  input  logic          pf_ready
);
  import pf_pkg::*;

  localparam int CNT_W = $clog2(max_int(ON_THRESH, OFF_THRESH) + 2);

  logic [NUM_OPS-1:0] issue_v;
  logic [AW-1:0]      target_v [NUM_OPS];
  logic               req;
  logic [AW-1:0]      req_addr;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_trk
    logic sel;
    assign sel = acc_valid && (acc_write == (g == int'(OP_WRITE)));
    pf_stride_track #(
      .AW    (AW),
      .CNT_W (CNT_W),
      .ON_TH (ON_THRESH),
      .OFF_TH(OFF_THRESH)
    ) trk_i (
      .clk   (clk),
      .rst   (rst),
      .en    (sel),
      .addr  (acc_addr),
      .issue (issue_v[g]),
      .target(target_v[g])
    );
  end

  // at most one tracker is enabled per cycle
  always_comb begin
    req      = 1'b0;
    req_addr = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (issue_v[i]) begin
        req      = 1'b1;
        req_addr = target_v[i];
      end
    end
  end

  pf_issue #(
    .AW        (AW),
    .LINE_BYTES(LINE_BYTES)
  ) iss_i (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .target  (req_addr),
    .pf_valid(pf_valid),
    .pf_addr (pf_addr),
    .pf_ready(pf_ready)
  );
endmodule

// File: rtl/stride_prefetch_chk.sv
module stride_prefetch_chk #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_valid,
  input logic          pf_valid,
  input logic [AW-1:0] pf_addr,
  input logic          pf_ready
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !pf_valid);

  assert_line_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (pf_addr[OFF_W-1:0] == '0));

  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready && !acc_valid) |=> (pf_valid && $stable(pf_addr)));

  assert_pending_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready) |=> pf_valid);

  assert_clear_on_take_R10: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && pf_ready && !acc_valid) |=> !pf_valid);

  assert_needs_access_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pf_valid) |-> $past(acc_valid));
endmodule

bind stride_prefetch stride_prefetch_chk #(
  .AW        (AW),
  .LINE_BYTES(LINE_BYTES)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .acc_valid(acc_valid),
  .pf_valid (pf_valid),
  .pf_addr  (pf_addr),
  .pf_ready (pf_ready)
);

// File: tb/stride_prefetch_tb_top.sv
module stride_prefetch_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        pf_ready = 1'b1;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string cur_req = "R1";

  // bench model state, written from the requirements
  bit          m_seen [2];
  bit          m_act  [2];
  logic [31:0] m_prev [2];
  logic [31:0] m_stride [2];
  int          m_same [2];
  int          m_diff [2];
  bit          m_lv;
  logic [31:0] m_last;
  bit          e_valid;
  logic [31:0] e_addr;

  always #5 clk = ~clk;

  stride_prefetch dut_i (
    .clk      (clk),
    .rst      (rst),
    .acc_valid(acc_valid),
    .acc_addr (acc_addr),
    .acc_write(acc_write),
    .pf_valid (pf_valid),
    .pf_addr  (pf_addr),
    .pf_ready (pf_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 2; i++) begin
      m_seen[i] = 0; m_act[i] = 0; m_prev[i] = '0;
      m_stride[i] = '0; m_same[i] = 0; m_diff[i] = 0;
    end
    m_lv = 0; m_last = '0; e_valid = 0; e_addr = '0;
  endfunction

  function automatic void model_step(input bit v, input logic [31:0] a, input bit w, input bit r);
    bit req = 0;
    logic [31:0] tgt = '0;
    logic [31:0] line;
    int t = w ? 1 : 0;
    if (v) begin
      if (!m_seen[t]) begin
        m_seen[t] = 1; m_prev[t] = a;
      end else begin
        logic [31:0] d = a - m_prev[t];
        m_prev[t] = a;
        if (m_act[t]) begin
          if (d == m_stride[t]) begin
            m_diff[t] = 0; req = 1; tgt = a + m_stride[t];
          end else begin
            m_diff[t]++;
            if (m_diff[t] > 3) begin
              m_act[t] = 0; m_stride[t] = d; m_same[t] = 1; m_diff[t] = 0;
            end
          end
        end else if (d == m_stride[t]) begin
          m_same[t]++;
          if (m_same[t] > 3) begin
            m_act[t] = 1; m_diff[t] = 0; req = 1; tgt = a + m_stride[t];
          end
        end else begin
          m_stride[t] = d; m_same[t] = 1;
        end
      end
    end
    line = tgt & ~32'h3F;
    if (req && !(m_lv && line == m_last)) begin
      e_valid = 1; e_addr = line; m_last = line; m_lv = 1;
    end else if (r) begin
      e_valid = 0;
    end
  endfunction

  // called at a negedge; drives, advances one edge, checks at the next negedge
  task automatic cyc(input bit v, input logic [31:0] a, input bit w, input bit r);
    acc_valid = v; acc_addr = a; acc_write = w; pf_ready = r;
    model_step(v, a, w, r);
    @(posedge clk);
    @(negedge clk);
    check(cur_req, {31'd0, pf_valid}, {31'd0, e_valid});
    if (e_valid) check(cur_req, pf_addr, e_addr);
  endtask

  task automatic do_reset();
    rst = 1'b1; acc_valid = 0; pf_ready = 1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R1", {31'd0, pf_valid}, 32'd0);
    check("R1", pf_addr, 32'd0);
  endtask

  task automatic rd_stream(input logic [31:0] base, input logic [31:0] step, input int n, input bit r);
    for (int k = 0; k < n; k++) cyc(1, base + k * step, 0, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rb, wb, rs, ws;
    logic [31:0] strides [5];
    void'($urandom(32'd2024));
    strides[0] = 32'h40; strides[1] = 32'h80; strides[2] = -32'sh40;
    strides[3] = 32'h8;  strides[4] = 32'h100;

    @(negedge clk);
    cur_req = "R1"; do_reset();

    // R2: first access per type only records
    cur_req = "R2";
    cyc(1, 32'h1000, 0, 1); check("R2", {31'd0, pf_valid}, 32'd0);
    cyc(1, 32'h9000, 1, 1); check("R2", {31'd0, pf_valid}, 32'd0);

    // R4: activation on the fourth equal stride
    do_reset(); cur_req = "R4";
    rd_stream(32'h1000, 32'h40, 4, 1);
    check("R4", {31'd0, pf_valid}, 32'd0);
    cyc(1, 32'h1100, 0, 1);
    check("R4", pf_addr, 32'h1140);

    // R5: matching accesses keep prefetching; fresh request while ready high
    cur_req = "R5";
    cyc(1, 32'h1140, 0, 1); check("R5", pf_addr, 32'h1180);
    check("R5", {31'd0, pf_valid}, 32'd1);

    // R3: interleaved writes with their own stride
    cur_req = "R3";
    for (int k = 0; k < 6; k++) begin
      cyc(1, 32'h2000 + k * 32'h100, 1, 1);
      cyc(1, 32'h1180 + k * 32'h40, 0, 1);
      check("R3", pf_addr, 32'h11C0 + k * 32'h40);
    end

    // R8: sub-line stride, alignment and same-line suppression
    do_reset(); cur_req = "R8";
    rd_stream(32'h3004, 32'h8, 5, 1);
    check("R8", pf_addr, 32'h3000);
    cyc(1, 32'h302C, 0, 1);
    check("R8", {31'd0, pf_valid}, 32'd0);

    // R6: deactivation after four differing strides, a match in between clears
    do_reset(); cur_req = "R6";
    rd_stream(32'h4000, 32'h40, 5, 1);
    cyc(1, 32'h5000, 0, 1); cyc(1, 32'h5010, 0, 1); cyc(1, 32'h5100, 0, 1);
    cyc(1, 32'h5140, 0, 1); check("R6", pf_addr, 32'h5180);
    cyc(1, 32'h6000, 0, 1); cyc(1, 32'h6008, 0, 1); cyc(1, 32'h7000, 0, 1);
    cyc(1, 32'h7100, 0, 1);
    cyc(1, 32'h7140, 0, 1); check("R6", {31'd0, pf_valid}, 32'd0);

    // R7: replaced stride restarts the count at one
    cur_req = "R7";
    cyc(1, 32'h7180, 0, 1); cyc(1, 32'h71C0, 0, 1);
    check("R7", {31'd0, pf_valid}, 32'd0);
    cyc(1, 32'h7200, 0, 1); check("R7", pf_addr, 32'h7240);

    // R9: stalled output holds, then is replaced; R10: taken and cleared
    do_reset(); cur_req = "R9";
    rd_stream(32'h8000, 32'h40, 5, 0);
    check("R9", pf_addr, 32'h8140);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    check("R9", pf_addr, 32'h8140);
    cyc(1, 32'h8140, 0, 0); check("R9", pf_addr, 32'h8180);
    cur_req = "R10";
    cyc(0, 0, 0, 1); check("R10", {31'd0, pf_valid}, 32'd0);

    // random mixed traffic
    do_reset(); cur_req = "R5";
    rb = 32'h10000; wb = 32'h80000; rs = 32'h40; ws = 32'h80;
    for (int k = 0; k < 4000; k++) begin
      bit v = ($urandom % 4) != 0;
      bit w = ($urandom % 3) == 0;
      bit r = ($urandom % 4) != 0;
      logic [31:0] a;
      if ($urandom % 40 == 0) rs = strides[$urandom % 5];
      if ($urandom % 40 == 0) ws = strides[$urandom % 5];
      if (w) begin
        wb = ($urandom % 12 == 0) ? $urandom : wb + ws; a = wb;
      end else begin
        rb = ($urandom % 12 == 0) ? $urandom : rb + rs; a = rb;
      end
      if (v) cyc(1, a, w, r); else cyc(0, 0, 0, r);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule